// File: doc/BRIEF.md
# Flash Program/Erase Status Reporter

This block is the status side of a NOR-style flash controller. A command decoder upstream strobes `cmd_done_i` when the last write pulse of a program or erase sequence completes. The block then tracks the embedded operation: it lowers a ready line while work is in progress, lets an erase be suspended, accepts a program during that suspension, and resumes the erase when asked. The length of each operation is counted in pulses of an external timebase `tick_i`. Commands that hit protected sectors do no work. They still produce a short busy window of fixed length.

A read request returns, one clock later, either the constant array word (the memory array is stubbed) or a status word. A status word is the array word with two bits replaced. Bit 6 is the operation toggle: it inverts on every read while an operation runs. Bit 2 is the sector toggle: it inverts only on reads to sectors that are being erased or are erase-suspended. Software polls these bits to tell whether the device is busy, suspended, or finished. Read responses are a plain one-cycle valid pulse with no back-pressure. The requester must accept each response in the cycle after its request.

Top module: `flash_status_rpt`

## Requirements
- R1: `ready_o` is low while a program, erase or suspended-erase program is running, and high when idle or erase-suspended. It is registered: it changes at the same clock edge that accepts the command, expiry, suspend or resume. It is high after reset.
- R2: During a running operation every read returns a status word: `ARRAY_WORD` with bit 6 set to the operation toggle and bit 2 set to the sector toggle. The operation toggle inverts on each such read, at any sector, and the first read after an accepted command returns 1.
- R3: The sector toggle inverts on a status read whose sector is in the live erase set (selected and not protected) while erasing, erase-suspended, or programming inside a suspension. On every other read it holds its value.
- R4: `rsp_valid_o` pulses for exactly one cycle, in the cycle after `rd_req_i`, and at no other time.
- R5: A program lasts `PGM_TICKS` ticks, or `PROT_PGM_TICKS` ticks if its sector is protected. `ready_o` rises at the edge that takes the last tick.
- R6: An erase lasts `ERS_TICKS` ticks of running time if its live erase set is non-empty. If every selected sector is protected, or none is selected, it lasts `PROT_ERS_TICKS` ticks.
- R7: When idle, reads return `ARRAY_WORD`. When erase-suspended, reads to sectors outside the live erase set also return `ARRAY_WORD`.
- R8: A suspend request during an erase with a non-empty live set enters suspension at once. Ready goes high, the erase timer freezes, and the operation toggle holds while the sector toggle keeps inverting on reads in the set.
- R9: While suspended, a program command starts a busy program. When that program ends, the block returns to suspension. An erase command while suspended is ignored.
- R10: A resume request while suspended returns the block to erase. Ready goes low, and only the erase ticks that were not yet used remain.
- R11: An accepted command clears both toggles to 0. A command arriving while busy is ignored and leaves the toggles and the timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timebase pulse that counts operation time |
| cmd_done_i | input | 1 | Strobe: final write pulse of a command sequence completed |
| cmd_erase_i | input | 1 | Command kind with the strobe: 1 erase, 0 program |
| cmd_sect_i | input | SECT_W (3) | Program target sector |
| erase_sel_i | input | NUM_SECT (8) | Sectors selected for erase |
| prot_i | input | NUM_SECT (8) | Per-sector protection bits |
| susp_req_i | input | 1 | Erase-suspend request |
| resume_req_i | input | 1 | Erase-resume request |
| rd_req_i | input | 1 | Read strobe |
| rd_sect_i | input | SECT_W (3) | Sector addressed by the read |
| ready_o | output | 1 | High ready, low busy |
| rsp_valid_o | output | 1 | Read response valid, one cycle after the request |
| rsp_data_o | output | DATA_W (8) | Array word or status word |

## Verification
Reads are issued in several patterns. A run of reads to an unselected sector during a program shows the operation toggle alternating while the sector toggle stays put. Reads interleaved between a selected-unprotected and a selected-protected sector during erase separate the two toggles. Reads in and out of the erase set while suspended separate held status, toggling status and plain array data. Commands to protected sectors, a command sent while busy, an erase sent while suspended, and a suspend/resume with frozen ticks check that the busy windows have exactly the required length.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PGM  = 3'd1,
    ST_ERS  = 3'd2,
    ST_SUSP = 3'd3,
    ST_SPGM = 3'd4
  } fsr_state_e;

  // bit positions a host poll routine decodes
  localparam int OPTOG_BIT  = 6;
  localparam int SECTOG_BIT = 2;

  function automatic logic is_busy(fsr_state_e s);
    return (s == ST_PGM) || (s == ST_ERS) || (s == ST_SPGM);
  endfunction

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/fsr_tick_timer.sv
module fsr_tick_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expire_o = run_i && !load_i && (cnt_q == CNT_W'(1));
  assign count_o  = cnt_q;

endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
#(
  parameter int NUM_SECT       = 8,
  parameter int CNT_W          = 8,
  parameter int PGM_TICKS      = 4,
  parameter int ERS_TICKS      = 16,
  parameter int PROT_PGM_TICKS = 1,
  parameter int PROT_ERS_TICKS = 100,
  localparam int SECT_W        = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                cmd_done_i,
  input  logic                cmd_erase_i,
  input  logic [SECT_W-1:0]   cmd_sect_i,
  input  logic [NUM_SECT-1:0] erase_sel_i,
  input  logic [NUM_SECT-1:0] prot_i,
  input  logic                susp_req_i,
  input  logic                resume_req_i,
  input  logic                pgm_exp_i,
  input  logic                ers_exp_i,
  output fsr_state_e          state_o,
  output logic                pgm_load_o,
  output logic [CNT_W-1:0]    pgm_val_o,
  output logic                pgm_run_o,
  output logic                ers_load_o,
  output logic [CNT_W-1:0]    ers_val_o,
  output logic                ers_run_o,
  output logic [NUM_SECT-1:0] ers_set_o,
  output logic                cmd_acc_o,
  output logic                ready_o
);

  fsr_state_e          state_q, state_d;
  logic [NUM_SECT-1:0] set_q, set_d;
  logic [NUM_SECT-1:0] live_sel;
  logic                susp_ok;

  assign live_sel  = erase_sel_i & ~prot_i;
  assign susp_ok   = susp_req_i && (set_q != '0);
  assign pgm_val_o = prot_i[cmd_sect_i] ? CNT_W'(PROT_PGM_TICKS) : CNT_W'(PGM_TICKS);
  assign ers_val_o = (live_sel == '0) ? CNT_W'(PROT_ERS_TICKS) : CNT_W'(ERS_TICKS);
  assign pgm_run_o = tick_i && ((state_q == ST_PGM) || (state_q == ST_SPGM));
  assign ers_run_o = tick_i && (state_q == ST_ERS) && !susp_ok;

  always_comb begin
    state_d    = state_q;
    set_d      = set_q;
    pgm_load_o = 1'b0;
    ers_load_o = 1'b0;
    cmd_acc_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_done_i) begin
          cmd_acc_o = 1'b1;
          if (cmd_erase_i) begin
            state_d    = ST_ERS;
            ers_load_o = 1'b1;
            set_d      = live_sel;
          end else begin
            state_d    = ST_PGM;
            pgm_load_o = 1'b1;
            set_d      = '0;
          end
        end
      end
      ST_PGM: begin
        if (pgm_exp_i) state_d = ST_IDLE;
      end
      ST_ERS: begin
        if (susp_ok) begin
          state_d = ST_SUSP;
        end else if (ers_exp_i) begin
          state_d = ST_IDLE;
          set_d   = '0;
        end
      end
      ST_SUSP: begin
        if (cmd_done_i && !cmd_erase_i) begin
          cmd_acc_o  = 1'b1;
          pgm_load_o = 1'b1;
          state_d    = ST_SPGM;
        end else if (resume_req_i) begin
          state_d = ST_ERS;
        end
      end
      ST_SPGM: begin
        if (pgm_exp_i) state_d = ST_SUSP;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      set_q   <= '0;
      ready_o <= 1'b1;
    end else begin
      state_q <= state_d;
      set_q   <= set_d;
      ready_o <= !is_busy(state_d);
    end
  end

  assign state_o   = state_q;
  assign ers_set_o = set_q;

endmodule

// File: rtl/fsr_status_out.sv
module fsr_status_out
  import fsr_pkg::*;
#(
  parameter int              NUM_SECT   = 8,
  parameter int              DATA_W     = 8,
  parameter logic [DATA_W-1:0] ARRAY_WORD = '0,
  localparam int             SECT_W     = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  fsr_state_e          state_i,
  input  logic [NUM_SECT-1:0] ers_set_i,
  input  logic                cmd_acc_i,
  input  logic                rd_req_i,
  input  logic [SECT_W-1:0]   rd_sect_i,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_data_o,
  output logic                optog_o,
  output logic                sectog_o
);

  logic optog_q, sectog_q, optog_d, sectog_d;
  logic hit, busy, status_rd;
  logic [DATA_W-1:0] status_word;

  assign hit       = ers_set_i[rd_sect_i];
  assign busy      = is_busy(state_i);
  assign status_rd = rd_req_i && (busy || ((state_i == ST_SUSP) && hit));
  assign optog_d   = optog_q ^ (rd_req_i && busy);
  assign sectog_d  = sectog_q ^ (status_rd && hit);

  always_comb begin
    status_word             = ARRAY_WORD;
    status_word[OPTOG_BIT]  = optog_d;
    status_word[SECTOG_BIT] = sectog_d;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      optog_q     <= 1'b0;
      sectog_q    <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      if (cmd_acc_i) begin
        optog_q  <= 1'b0;
        sectog_q <= 1'b0;
      end else begin
        optog_q  <= optog_d;
        sectog_q <= sectog_d;
      end
      rsp_valid_o <= rd_req_i;
      if (rd_req_i) rsp_data_o <= status_rd ? status_word : ARRAY_WORD;
    end
  end

  assign optog_o  = optog_q;
  assign sectog_o = sectog_q;

endmodule

// File: rtl/flash_status_rpt.sv
module flash_status_rpt
  import fsr_pkg::*;
#(
  parameter int                NUM_SECT       = 8,
  parameter int                DATA_W         = 8,
  parameter logic [DATA_W-1:0] ARRAY_WORD     = 8'h3C,
  parameter int                PGM_TICKS      = 4,
  parameter int                ERS_TICKS      = 16,
  parameter int                PROT_PGM_TICKS = 1,
  parameter int                PROT_ERS_TICKS = 100,
  localparam int               SECT_W         = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1,
  localparam int               MAX_TICKS      = max4(PGM_TICKS, ERS_TICKS, PROT_PGM_TICKS, PROT_ERS_TICKS),
  localparam int               CNT_W          = $clog2(MAX_TICKS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                cmd_done_i,
  input  logic                cmd_erase_i,
  input  logic [SECT_W-1:0]   cmd_sect_i,
  input  logic [NUM_SECT-1:0] erase_sel_i,
  input  logic [NUM_SECT-1:0] prot_i,
  input  logic                susp_req_i,
  input  logic                resume_req_i,
  input  logic                rd_req_i,
  input  logic [SECT_W-1:0]   rd_sect_i,
  output logic                ready_o,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_data_o
);

  fsr_state_e          st;
  logic                pgm_load, pgm_run, pgm_exp;
  logic                ers_load, ers_run, ers_exp;
  logic [CNT_W-1:0]    pgm_val, ers_val, pgm_cnt, ers_cnt;
  logic [NUM_SECT-1:0] ers_set;
  logic                cmd_acc, optog, sectog;

  fsr_ctrl #(
    .NUM_SECT(NUM_SECT), .CNT_W(CNT_W), .PGM_TICKS(PGM_TICKS), .ERS_TICKS(ERS_TICKS),
    .PROT_PGM_TICKS(PROT_PGM_TICKS), .PROT_ERS_TICKS(PROT_ERS_TICKS)
  ) u_ctrl (
    .clk_i, .rst_ni, .tick_i, .cmd_done_i, .cmd_erase_i, .cmd_sect_i,
    .erase_sel_i, .prot_i, .susp_req_i, .resume_req_i,
    .pgm_exp_i(pgm_exp), .ers_exp_i(ers_exp),
    .state_o(st),
    .pgm_load_o(pgm_load), .pgm_val_o(pgm_val), .pgm_run_o(pgm_run),
    .ers_load_o(ers_load), .ers_val_o(ers_val), .ers_run_o(ers_run),
    .ers_set_o(ers_set), .cmd_acc_o(cmd_acc), .ready_o
  );

  fsr_tick_timer #(.CNT_W(CNT_W)) u_pgm_tmr (
    .clk_i, .rst_ni, .load_i(pgm_load), .load_val_i(pgm_val), .run_i(pgm_run),
    .expire_o(pgm_exp), .count_o(pgm_cnt)
  );

  fsr_tick_timer #(.CNT_W(CNT_W)) u_ers_tmr (
    .clk_i, .rst_ni, .load_i(ers_load), .load_val_i(ers_val), .run_i(ers_run),
    .expire_o(ers_exp), .count_o(ers_cnt)
  );

  fsr_status_out #(
    .NUM_SECT(NUM_SECT), .DATA_W(DATA_W), .ARRAY_WORD(ARRAY_WORD)
  ) u_status (
    .clk_i, .rst_ni, .state_i(st), .ers_set_i(ers_set), .cmd_acc_i(cmd_acc),
    .rd_req_i, .rd_sect_i, .rsp_valid_o, .rsp_data_o,
    .optog_o(optog), .sectog_o(sectog)
  );

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
  import fsr_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] ARRAY_WORD = '0,
  parameter int                CNT_W      = 8
) (
  input logic              clk,
  input logic              rst_n,
  input fsr_state_e        state,
  input logic              ready,
  input logic              rd_req,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              optog,
  input logic              sectog,
  input logic              cmd_acc,
  input logic              resume_req,
  input logic [CNT_W-1:0]  pgm_cnt,
  input logic [CNT_W-1:0]  ers_cnt
);

  assert_ready_tracks_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready == !is_busy(state));

  assert_optog_flips_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && is_busy(state) && !cmd_acc) |=> (optog != $past(optog)));

  assert_rsp_follows_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);

  assert_no_stray_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid);

  assert_pgm_timer_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_PGM) || (state == ST_SPGM)) |-> (pgm_cnt != '0));

  assert_idle_array_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && state == ST_IDLE) |=> (rsp_data == ARRAY_WORD));

  assert_susp_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SUSP && !resume_req) |=> $stable(ers_cnt));

  assert_cmd_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_acc |=> (!optog && !sectog));

endmodule

bind flash_status_rpt fsr_checker #(
  .DATA_W(DATA_W), .ARRAY_WORD(ARRAY_WORD), .CNT_W(CNT_W)
) u_fsr_chk (
  .clk(clk_i), .rst_n(rst_ni), .state(st), .ready(ready_o), .rd_req(rd_req_i),
  .rsp_valid(rsp_valid_o), .rsp_data(rsp_data_o), .optog(optog), .sectog(sectog),
  .cmd_acc(cmd_acc), .resume_req(resume_req_i), .pgm_cnt(pgm_cnt), .ers_cnt(ers_cnt)
);

// File: tb/flash_status_rpt_bench.sv
module flash_status_rpt_bench;

  localparam int          NS    = 8;
  localparam logic [7:0]  ARR   = 8'h3C;
  localparam int          T_PGM = 6;
  localparam int          T_ERS = 12;
  localparam int          T_PP  = 2;
  localparam int          T_PE  = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, cmd_done = 1'b0, cmd_erase = 1'b0;
  logic [2:0] cmd_sect = '0, rd_sect = '0;
  logic [7:0] sel = '0, prot = '0;
  logic       susp = 1'b0, resume = 1'b0, rd_req = 1'b0;
  logic       ready, rsp_valid;
  logic [7:0] rsp_data;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // bench model: 0 idle, 1 busy, 2 suspended
  int         bmode = 0;
  logic       b6 = 1'b0, b2 = 1'b0;
  logic [7:0] bset = '0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  flash_status_rpt #(
    .NUM_SECT(NS), .DATA_W(8), .ARRAY_WORD(ARR), .PGM_TICKS(T_PGM), .ERS_TICKS(T_ERS),
    .PROT_PGM_TICKS(T_PP), .PROT_ERS_TICKS(T_PE)
  ) u_flash_status_rpt (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cmd_done_i(cmd_done),
    .cmd_erase_i(cmd_erase), .cmd_sect_i(cmd_sect), .erase_sel_i(sel), .prot_i(prot),
    .susp_req_i(susp), .resume_req_i(resume), .rd_req_i(rd_req), .rd_sect_i(rd_sect),
    .ready_o(ready), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data)
  );

  function automatic logic [7:0] stat_word(logic t6, logic t2);
    logic [7:0] w;
    w = ARR;
    w[6] = t6;
    w[2] = t2;
    return w;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // monitor: pops the scoreboard on each response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected response", 32'(rsp_data), 32'hFFFF_FFFF);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_data == e, t, 32'(rsp_data), 32'(e));
      end
    end
  end

  task automatic do_read(int s, string tag);
    logic [7:0] e;
    if (bmode == 1) begin
      b6 = ~b6;
      if (bset[s]) b2 = ~b2;
      e = stat_word(b6, b2);
    end else if (bmode == 2 && bset[s]) begin
      b2 = ~b2;
      e = stat_word(b6, b2);
    end else begin
      e = ARR;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_req  = 1'b1;
    rd_sect = 3'(s);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic do_cmd(bit er, int s, logic [7:0] selv);
    @(negedge clk);
    cmd_done  = 1'b1;
    cmd_erase = er;
    cmd_sect  = 3'(s);
    sel       = selv;
    @(negedge clk);
    cmd_done = 1'b0;
  endtask

  task automatic pulse_susp(bit r);
    @(negedge clk);
    if (r) resume = 1'b1; else susp = 1'b1;
    @(negedge clk);
    resume = 1'b0;
    susp   = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic chk_ready(logic e, string tag);
    check(ready == e, tag, 32'(ready), 32'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    prot = 8'h08;   // sector 3 protected
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_ready(1'b1, "R1 ready after reset");
    check(rsp_valid == 1'b0, "R4 no response after reset", 32'(rsp_valid), 0);
    do_read(5, "R7 idle read returns array word");

    // program to unprotected sector 1; busy command ignored midway
    do_cmd(1'b0, 1, 8'h00);
    bmode = 1; b6 = 0; b2 = 0; bset = '0;
    chk_ready(1'b0, "R1 busy during program");
    do_read(0, "R2 first status read");
    do_read(5, "R2 second status read");
    do_read(1, "R3 sector toggle holds outside erase");
    ticks(2);
    do_cmd(1'b1, 0, 8'hFF);
    chk_ready(1'b0, "R11 busy command ignored");
    do_read(2, "R11 toggles not cleared by ignored command");
    ticks(T_PGM - 3);
    chk_ready(1'b0, "R5 program one tick before end");
    ticks(1);
    bmode = 0;
    chk_ready(1'b1, "R5 program ends after PGM ticks");
    do_read(1, "R7 array after program");

    // program to protected sector 3
    do_cmd(1'b0, 3, 8'h00);
    bmode = 1; b6 = 0; b2 = 0;
    chk_ready(1'b0, "R5 protected program busy");
    do_read(3, "R2 toggle during protected program");
    ticks(T_PP - 1);
    chk_ready(1'b0, "R5 protected program window");
    ticks(1);
    bmode = 0;
    chk_ready(1'b1, "R5 protected program short window");

    // erase where all selected sectors are protected
    do_cmd(1'b1, 0, 8'h08);
    bmode = 1; b6 = 0; b2 = 0; bset = '0;
    do_read(3, "R6 all-protected erase status, sector toggle holds");
    do_read(3, "R6 all-protected erase second read");
    ticks(T_PE - 1);
    chk_ready(1'b0, "R6 all-protected erase window");
    ticks(1);
    bmode = 0;
    chk_ready(1'b1, "R6 all-protected erase ends");
    do_read(3, "R6 array after protected erase");

    // erase sectors 2 and 3 (3 protected): live set is sector 2
    do_cmd(1'b1, 0, 8'h0C);
    bmode = 1; b6 = 0; b2 = 0; bset = 8'h04;
    do_read(2, "R3 sector toggle on live sector");
    do_read(3, "R3 sector toggle holds on protected sector");
    do_read(2, "R3 sector toggle again");
    ticks(4);
    pulse_susp(1'b0);
    bmode = 2;
    chk_ready(1'b1, "R8 ready in suspend");
    do_read(2, "R8 suspended read, op toggle held");
    do_read(2, "R8 suspended read, sector toggle keeps flipping");
    do_read(0, "R7 suspended read outside set");
    ticks(3);
    chk_ready(1'b1, "R8 ticks ignored in suspend");
    do_cmd(1'b1, 0, 8'hFF);
    chk_ready(1'b1, "R9 erase in suspend ignored");
    do_read(2, "R9 toggles kept after ignored erase");
    do_cmd(1'b0, 0, 8'h0C);
    bmode = 1; b6 = 0; b2 = 0;
    chk_ready(1'b0, "R9 program in suspend busy");
    do_read(0, "R9 suspended program status");
    do_read(2, "R3 sector toggle during suspended program");
    ticks(T_PGM);
    bmode = 2;
    chk_ready(1'b1, "R9 back to suspend");
    do_read(2, "R9 suspend status after program");
    pulse_susp(1'b1);
    bmode = 1;
    chk_ready(1'b0, "R10 resume goes busy");
    do_read(6, "R10 op toggle resumes");
    ticks(T_ERS - 4 - 1);
    chk_ready(1'b0, "R10 remaining erase ticks");
    ticks(1);
    bmode = 0; bset = '0;
    chk_ready(1'b1, "R6 erase ends after running ticks");
    do_read(2, "R7 array after erase");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R4 every read answered", 32'(exp_q.size()), 0);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule